// File: doc/BRIEF.md
# Serial NOR Flash Write-Protection Unit

This block keeps the status byte of a serial NOR flash device and rules on every request that would change the device contents or the status byte itself. A command decoder upstream hands it one-cycle strobes for write enable, write disable, status read, status write (with its data byte), page program, sector erase and bulk erase. It also receives a 32-bit target address and the level of the hardware write-protect pin. The array controller downstream acts only on requests that come back granted.

The protected area is a power-of-two count of 64 KiB sectors. A four-bit code picks the count. Its low three bits sit at status bits 4:2 and its high bit sits at status bit 6. Status bit 5 anchors the area at the top or the bottom of the array. Status bit 7 is a status-write lock, and it takes effect only while the write-protect pin is held low. Every modifying request consumes the write-enable latch (status bit 1), whether the request is granted or denied.

Each request is decided in the cycle it arrives. The verdict and the updated status appear one clock later.

Top module: `flash_wp_unit`

## Requirements
- R1: After reset, status_o, rd_status_o, grant_o and deny_o are all zero.
- R2: A write-enable strobe sets status bit 1 and a write-disable strobe clears it. When both arrive in the same cycle, the disable wins.
- R3: A modifying request (status write, page program, sector erase, bulk erase) that arrives while status bit 1 is 0 is denied and changes nothing. Status bit 1 reads 0 after any modifying request, whatever its verdict.
- R4: The protection code is {status[6], status[4:2]}. Code 0 protects nothing. A code N from 1 to 15 protects min(2^(N-1), 512) sectors. The sector index is addr_i[24:16], and the other address bits are ignored.
- R5: With status bit 5 at 0, the protected sectors are the highest ones (index >= 512 - count). With bit 5 at 1, they are the lowest ones (index < count).
- R6: A page program or sector erase whose sector is protected is denied. The same request aimed at an unprotected sector with the latch set is granted.
- R7: A bulk erase is denied whenever the protection count is nonzero. With the latch set and nothing protected, it is granted.
- R8: A status write with the latch set is accepted when wp_n_i is 1 or status bit 7 is 0. Bits 7:2 then take data bits 7:2, and bits 1:0 become 0.
- R9: A status write while wp_n_i is 0 and status bit 7 is 1 is denied. Status bits 7:2 keep their value.
- R10: When a write-enable or write-disable strobe arrives in the same cycle as a modifying request, the strobe is discarded. The request is judged on the latch value held before that cycle.
- R11: Each modifying request yields exactly one one-cycle pulse, on grant_o or on deny_o, in the cycle after the request. Read strobes and latch strobes yield neither. A status-read strobe loads the current status into rd_status_o one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| rdsr_i | input | 1 | Status-read strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 8 | Data byte carried by the status write |
| prog_i | input | 1 | Page-program request |
| serase_i | input | 1 | Sector-erase request |
| berase_i | input | 1 | Bulk-erase request |
| addr_i | input | 32 | Target byte address |
| wp_n_i | input | 1 | Write-protect pin level (low = protect) |
| status_o | output | 8 | Current status byte |
| rd_status_o | output | 8 | Status byte captured by the last status read |
| grant_o | output | 1 | Request accepted (one-cycle pulse) |
| deny_o | output | 1 | Request rejected (one-cycle pulse) |

## Verification
A latch strobe can land in the same cycle as a modifying request. The bench provokes this directly: it raises write enable together with a program while the latch is clear, and write disable together with a program while the latch is set. The first case must be denied and the second granted, and the latch must read 0 afterwards in both. The random phase also lays latch strobes over requests, and a bench model that applies R10 predicts every verdict and status byte.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_STATUS_WR,
    OP_CHIP_ERASE,
    OP_BLOCK_ERASE,
    OP_PAGE_PROG
  } mod_op_e;

  localparam int WEL_BIT  = 1;
  localparam int TB_BIT   = 5;
  localparam int LOCK_BIT = 7;

  function automatic logic [3:0] prot_code(input logic [7:0] sr);
    return {sr[6], sr[4:2]};
  endfunction

endpackage

// File: rtl/wp_region.sv
module wp_region #(
  parameter int NSECT_LOG2 = 9
) (
  input  logic [3:0]            code_i,
  input  logic                  bottom_i,
  input  logic [NSECT_LOG2-1:0] sector_i,
  output logic [NSECT_LOG2:0]   count_o,
  output logic                  hit_o
);
  localparam int CNT_W = NSECT_LOG2 + 1;
  localparam logic [CNT_W-1:0] FULL = {1'b1, {NSECT_LOG2{1'b0}}};

  logic [CNT_W-1:0] sec_ext;
  logic [CNT_W-1:0] top_sum;

  always_comb begin
    if (code_i == 4'd0) begin
      count_o = '0;
    end else if (int'(code_i) - 1 >= NSECT_LOG2) begin
      count_o = FULL;
    end else begin
      count_o = CNT_W'(1) << (code_i - 4'd1);
    end
  end

  assign sec_ext = {1'b0, sector_i};
  assign top_sum = sec_ext + count_o;

  always_comb begin
    if (bottom_i) hit_o = (sec_ext < count_o);
    else          hit_o = (top_sum >= FULL);
  end

endmodule

// File: rtl/wp_arbiter.sv
module wp_arbiter
  import flash_wp_pkg::*;
(
  input  logic    wrsr_i,
  input  logic    berase_i,
  input  logic    serase_i,
  input  logic    prog_i,
  input  logic    wel_i,
  input  logic    lock_i,
  input  logic    wp_n_i,
  input  logic    hit_i,
  input  logic    none_prot_i,
  output mod_op_e op_o,
  output logic    ok_o
);

  always_comb begin
    if (wrsr_i)        op_o = OP_STATUS_WR;
    else if (berase_i) op_o = OP_CHIP_ERASE;
    else if (serase_i) op_o = OP_BLOCK_ERASE;
    else if (prog_i)   op_o = OP_PAGE_PROG;
    else               op_o = OP_IDLE;
  end

  always_comb begin
    unique case (op_o)
      OP_STATUS_WR:   ok_o = wel_i & (wp_n_i | ~lock_i);
      OP_CHIP_ERASE:  ok_o = wel_i & none_prot_i;
      OP_BLOCK_ERASE,
      OP_PAGE_PROG:   ok_o = wel_i & ~hit_i;
      default:        ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/wp_status.sv
module wp_status
  import flash_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mod_op_e    op_i,
  input  logic       ok_i,
  input  logic       wren_i,
  input  logic       wrdi_i,
  input  logic [7:2] wr_data_i,
  output logic [7:0] status_o
);
  logic [7:0] sr_q;
  logic [7:0] sr_nx;
  logic       sr_en;

  assign sr_en = (op_i != OP_IDLE) | wren_i | wrdi_i;

  always_comb begin
    sr_nx = sr_q;
    if (op_i != OP_IDLE) begin
      sr_nx[WEL_BIT] = 1'b0;
      if (op_i == OP_STATUS_WR && ok_i) begin
        sr_nx = {wr_data_i, 2'b00};
      end
    end else if (wrdi_i) begin
      sr_nx[WEL_BIT] = 1'b0;
    end else if (wren_i) begin
      sr_nx[WEL_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_nx;
  end

  assign status_o = sr_q;

endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SECT_LOG2  = 16,
  parameter int NSECT_LOG2 = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wren_i,
  input  logic        wrdi_i,
  input  logic        rdsr_i,
  input  logic        wrsr_i,
  input  logic [7:0]  wrsr_data_i,
  input  logic        prog_i,
  input  logic        serase_i,
  input  logic        berase_i,
  input  logic [31:0] addr_i,
  input  logic        wp_n_i,
  output logic [7:0]  status_o,
  output logic [7:0]  rd_status_o,
  output logic        grant_o,
  output logic        deny_o
);
  localparam int SEC_HI = SECT_LOG2 + NSECT_LOG2;

  logic                  rst_meta_q;
  logic                  rst_sync_q;
  logic [7:0]            sr;
  logic [NSECT_LOG2:0]   prot_cnt;
  logic                  hit;
  mod_op_e               op;
  logic                  ok;
  logic                  grant_q, deny_q;
  logic [7:0]            rd_q;
  logic                  unused_bits;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign unused_bits = ^{addr_i[ADDR_W-1:SEC_HI], addr_i[SECT_LOG2-1:0],
                         wrsr_data_i[1:0]};

  wp_region #(.NSECT_LOG2(NSECT_LOG2)) i_region (
    .code_i   (prot_code(sr)),
    .bottom_i (sr[TB_BIT]),
    .sector_i (addr_i[SECT_LOG2 +: NSECT_LOG2]),
    .count_o  (prot_cnt),
    .hit_o    (hit)
  );

  wp_arbiter i_arbiter (
    .wrsr_i      (wrsr_i),
    .berase_i    (berase_i),
    .serase_i    (serase_i),
    .prog_i      (prog_i),
    .wel_i       (sr[WEL_BIT]),
    .lock_i      (sr[LOCK_BIT]),
    .wp_n_i      (wp_n_i),
    .hit_i       (hit),
    .none_prot_i (prot_cnt == '0),
    .op_o        (op),
    .ok_o        (ok)
  );

  wp_status i_status (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .op_i      (op),
    .ok_i      (ok),
    .wren_i    (wren_i),
    .wrdi_i    (wrdi_i),
    .wr_data_i (wrsr_data_i[7:2]),
    .status_o  (sr)
  );

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= (op != OP_IDLE) &  ok;
      deny_q  <= (op != OP_IDLE) & ~ok;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)  rd_q <= '0;
    else if (rdsr_i)  rd_q <= sr;
  end

  assign status_o    = sr;
  assign rd_status_o = rd_q;
  assign grant_o     = grant_q;
  assign deny_o      = deny_q;

endmodule

// File: rtl/flash_wp_unit_chk.sv
module flash_wp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic       wrsr_i,
  input logic       prog_i,
  input logic       serase_i,
  input logic       berase_i,
  input logic       wp_n_i,
  input logic [7:0] status_o,
  input logic       grant_o,
  input logic       deny_o
);
  logic any_mod;
  assign any_mod = wrsr_i | prog_i | serase_i | berase_i;

  a_r11_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && deny_o));

  a_r11_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
    any_mod |=> (grant_o || deny_o));

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !any_mod |=> !(grant_o || deny_o));

  a_r3_latch_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (any_mod && !status_o[1]) |=> deny_o);

  a_r3_latch_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    any_mod |=> !status_o[1]);

  a_r2_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_i && !wrdi_i && !any_mod) |=> status_o[1]);

  a_r9_locked_status: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !wp_n_i && status_o[7]) |=> ($stable(status_o[7:2]) && deny_o));

  a_r7_bulk_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (berase_i && !wrsr_i && ({status_o[6], status_o[4:2]} != 4'd0)) |=> deny_o);

endmodule

bind flash_wp_unit flash_wp_unit_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_q),
  .wren_i   (wren_i),
  .wrdi_i   (wrdi_i),
  .wrsr_i   (wrsr_i),
  .prog_i   (prog_i),
  .serase_i (serase_i),
  .berase_i (berase_i),
  .wp_n_i   (wp_n_i),
  .status_o (status_o),
  .grant_o  (grant_o),
  .deny_o   (deny_o)
);

// File: tb/test_flash_wp_unit.sv
module test_flash_wp_unit;
  localparam int K_WREN = 0, K_WRDI = 1, K_WRSR = 2, K_PROG = 3,
                 K_SER = 4, K_BER = 5, K_RDSR = 6, K_NOP = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wren_i = 0, wrdi_i = 0, rdsr_i = 0, wrsr_i = 0;
  logic [7:0]  wrsr_data_i = 0;
  logic        prog_i = 0, serase_i = 0, berase_i = 0;
  logic [31:0] addr_i = 0;
  logic        wp_n_i = 1;
  logic [7:0]  status_o, rd_status_o;
  logic        grant_o, deny_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_sr;
  bit         m_arr [512];

  always #2 clk = ~clk;

  flash_wp_unit i_flash_wp_unit (
    .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .rdsr_i(rdsr_i), .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i),
    .prog_i(prog_i), .serase_i(serase_i), .berase_i(berase_i),
    .addr_i(addr_i), .wp_n_i(wp_n_i), .status_o(status_o),
    .rd_status_o(rd_status_o), .grant_o(grant_o), .deny_o(deny_o)
  );

  function automatic int exp_count(logic [7:0] sr);
    int c;
    c = int'({sr[6], sr[4:2]});
    if (c == 0) return 0;
    if (c - 1 >= 9) return 512;
    return 1 << (c - 1);
  endfunction

  function automatic bit exp_hit(logic [7:0] sr, logic [31:0] a);
    int s, n;
    s = int'(a[24:16]);
    n = exp_count(sr);
    return sr[5] ? (s < n) : (s >= 512 - n);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one command; optional latch strobes laid over it (R10)
  task automatic issue(int kind, logic [7:0] d, logic [31:0] a, bit wp,
                       bit xwren, bit xwrdi, string tag);
    bit mod, ok, eg, ed;
    logic [7:0] old_sr;
    string req;
    old_sr = m_sr;
    mod = (kind == K_WRSR) || (kind == K_PROG) || (kind == K_SER) || (kind == K_BER);
    ok = 0;
    req = tag;
    case (kind)
      K_WRSR: begin
        ok = m_sr[1] && (wp || !m_sr[7]);
        if (req == "") req = (!wp && m_sr[7]) ? "R9" : "R8";
      end
      K_PROG, K_SER: begin
        ok = m_sr[1] && !exp_hit(m_sr, a);
        if (req == "") req = "R6";
      end
      K_BER: begin
        ok = m_sr[1] && (exp_count(m_sr) == 0);
        if (req == "") req = "R7";
      end
      default: if (req == "") req = "R2";
    endcase
    if (mod && !m_sr[1] && tag == "") req = "R3";
    if (mod) begin
      m_sr[1] = 1'b0;
      if (kind == K_WRSR && ok) m_sr = {d[7:2], 2'b00};
      if (kind == K_PROG && ok) m_arr[a[24:16]] = 1'b1;
      if (kind == K_SER && ok)  m_arr[a[24:16]] = 1'b0;
      if (kind == K_BER && ok)  foreach (m_arr[i]) m_arr[i] = 1'b0;
    end else if (kind == K_WRDI || xwrdi) begin
      m_sr[1] = 1'b0;
    end else if (kind == K_WREN || xwren) begin
      m_sr[1] = 1'b1;
    end
    eg = mod && ok;
    ed = mod && !ok;

    @(negedge clk);
    wren_i = (kind == K_WREN) || xwren;
    wrdi_i = (kind == K_WRDI) || xwrdi;
    rdsr_i = (kind == K_RDSR);
    wrsr_i = (kind == K_WRSR);
    prog_i = (kind == K_PROG);
    serase_i = (kind == K_SER);
    berase_i = (kind == K_BER);
    wrsr_data_i = d;
    addr_i = a;
    wp_n_i = wp;
    @(negedge clk);
    {wren_i, wrdi_i, rdsr_i, wrsr_i, prog_i, serase_i, berase_i} = '0;
    chk({grant_o, deny_o} == {eg, ed}, req, "grant/deny",
        int'({grant_o, deny_o}), int'({eg, ed}));
    chk(status_o == m_sr, req, "status", int'(status_o), int'(m_sr));
    if (kind == K_RDSR)
      chk(rd_status_o == old_sr, "R11", "read status", int'(rd_status_o), int'(old_sr));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1 - 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    m_sr = '0;
    foreach (m_arr[i]) m_arr[i] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(status_o == 8'h00 && rd_status_o == 8'h00, "R1", "status after reset",
        int'({status_o, rd_status_o}), 0);
    chk(!grant_o && !deny_o, "R1", "verdict after reset", int'({grant_o, deny_o}), 0);

    // R2 latch strobes
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_WRDI, 0, 0, 1, 0, 0, "R2");
    issue(K_WREN, 0, 0, 1, 0, 1, "R2");          // both together: disable wins
    issue(K_RDSR, 0, 0, 1, 0, 0, "R11");

    // R3 latch clear
    issue(K_PROG, 0, 32'h0000_0000, 1, 0, 0, "R3");

    // R4/R5 code 1, top: sector 511 protected, 510 not
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_WRSR, 8'h04, 0, 1, 0, 0, "R8");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_PROG, 0, 32'h01FF_0000, 1, 0, 0, "R5");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_PROG, 0, 32'h01FE_0000, 1, 0, 0, "R5");
    // R11 no pulse on an idle cycle
    @(negedge clk);
    chk(!grant_o && !deny_o, "R11", "pulse width", int'({grant_o, deny_o}), 0);
    // address bits above bit 24 ignored
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_SER, 0, 32'hFFFF_FFFF, 1, 0, 0, "R4");

    // bottom, code 1
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_WRSR, 8'h24, 0, 1, 0, 0, "R8");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_PROG, 0, 32'h0000_0100, 1, 0, 0, "R5");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_PROG, 0, 32'h0001_0000, 1, 0, 0, "R5");

    // code 9 (bit 6 + 001): 256 top sectors
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_WRSR, 8'h44, 0, 1, 0, 0, "R8");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_PROG, 0, 32'h0100_0000, 1, 0, 0, "R4");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_PROG, 0, 32'h00FF_0000, 1, 0, 0, "R4");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_BER, 0, 0, 1, 0, 0, "R7");

    // code 15 saturates to whole array
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_WRSR, 8'h5C, 0, 1, 0, 0, "R8");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_SER, 0, 32'h0000_0000, 1, 0, 0, "R4");

    // lock bit with pin low
    issue(K_WREN, 0, 0, 0, 0, 0, "R2");
    issue(K_WRSR, 8'h80, 0, 0, 0, 0, "R8");
    issue(K_WREN, 0, 0, 0, 0, 0, "R2");
    issue(K_WRSR, 8'h00, 0, 0, 0, 0, "R9");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_WRSR, 8'h00, 0, 1, 0, 0, "R8");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_BER, 0, 0, 1, 0, 0, "R7");

    // R10 latch strobes over requests
    issue(K_PROG, 0, 32'h0002_0000, 1, 1, 0, "R10");
    issue(K_WREN, 0, 0, 1, 0, 0, "R2");
    issue(K_PROG, 0, 32'h0002_0000, 1, 0, 1, "R10");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int r, k;
      r = int'($urandom_range(99));
      if (r < 35) k = K_WREN;
      else if (r < 40) k = K_WRDI;
      else if (r < 52) k = K_WRSR;
      else if (r < 70) k = K_PROG;
      else if (r < 82) k = K_SER;
      else if (r < 86) k = K_BER;
      else if (r < 94) k = K_RDSR;
      else k = K_NOP;
      issue(k, 8'($urandom), $urandom, ($urandom_range(3) != 0),
            ($urandom_range(9) == 0), ($urandom_range(19) == 0), "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule